// File: doc/BRIEF.md
# Address Translation Buffer with Table Walker

This block maps 32-bit word addresses issued by a processor onto physical word addresses. A virtual address splits into a 20-bit virtual page number (upper bits) and a 12-bit word offset (lower bits), since each page is 4K words. A small fully associative buffer caches recent page mappings. When the page is in the buffer, the block returns the translation on the clock edge after the request.

When the buffer misses, the block forms the table entry address by adding the page number to a base register. It reads that entry over a request/acknowledge port. If the entry is valid, the block installs it in the buffer and returns the translation. If the entry is invalid, the page is not resident, and the block pulses a fault output. Each buffer entry keeps a use bit and a modified bit. The use bit steers replacement. The modified bit is set by writes and is reported with each translation.

Software-side control is limited to two inputs. One loads the base register. The other invalidates the whole buffer.

Top module: `vpn_xlate`

## Requirements
- R1: A request accepted while idle whose page number matches a valid entry produces `resp_valid` high for one cycle on the next edge. `resp_paddr` then equals {entry physical page, request offset}. Neither `busy` nor `mem_req` rises.
- R2: A request that misses raises `busy` and `mem_req` on the next edge. `mem_addr` equals base register + page number, modulo 2^32. Both `mem_req` and `mem_addr` hold until `mem_ack` is sampled high.
- R3: A table entry read through `mem_rdata` has the valid flag in bit 21, the modified flag in bit 20 and the physical page in bits 19:0. When `mem_ack` is sampled with a valid entry, the next edge gives `resp_valid` high with the translated address, and `busy` and `mem_req` low.
- R4: When `mem_ack` is sampled with an invalid entry, the next edge gives `fault` high for one cycle and `resp_valid` stays low. No entry is installed, so a repeat of the same page walks again.
- R5: `resp_dirty` reports the used entry's modified flag after the access. A write sets it. A read leaves it unchanged, so a read of a page whose table entry is clean reports 0. Every access sets the entry's use bit.
- R6: A refill replaces the lowest-numbered invalid entry if one exists.
- R7: With all entries valid, a refill replaces the lowest-numbered entry whose use bit is 0. If every use bit is 1, all use bits are cleared and entry 0 is replaced.
- R8: A cycle with `flush` high invalidates every entry, so later accesses to previously held pages walk the table.
- R9: `base_we` high loads `base_wdata` into the base register. Walks that start afterwards use the new value.
- R10: A request is ignored while `busy` is high or while `flush` is high. Such a request gives no response and does not start a walk.
- R11: After reset, `busy`, `mem_req`, `resp_valid` and `fault` are low, the buffer is empty and the base register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_write | input | 1 | Request is a write access |
| req_vaddr | input | 32 | Virtual word address |
| resp_valid | output | 1 | Translation result valid (one cycle) |
| resp_paddr | output | 32 | Physical word address |
| resp_dirty | output | 1 | Modified flag of the used page |
| fault | output | 1 | Page not resident (one cycle) |
| busy | output | 1 | Table walk in progress |
| base_we | input | 1 | Load the table base register |
| base_wdata | input | 32 | New table base value |
| flush | input | 1 | Invalidate all buffer entries |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 32 | Table entry address |
| mem_ack | input | 1 | Table read acknowledge, data valid |
| mem_rdata | input | 22 | Table entry: valid, modified, physical page |

## Verification
A corrupted tag, page or valid bit shows up on the very next access to that page. It appears either as a wrong physical address one edge after the request, or as an unexpected table read where a hit was due. A wrong use bit or a wrong victim stays hidden until a later miss evicts the wrong entry. It only appears when the evicted page is touched again and walks instead of hitting. For that reason the sweep revisits every page many times across evictions. A wrong modified flag is visible at `resp_dirty` on the next access to that page.

// File: rtl/vpn_xlate_pkg.sv
package vpn_xlate_pkg;

    typedef enum logic [0:0] {
        XL_IDLE = 1'b0,
        XL_WALK = 1'b1
    } xl_state_e;

endpackage

// File: rtl/xl_match.sv
module xl_match #(
    parameter int N     = 4,
    parameter int VPN_W = 20,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]            valid,
    input  logic [N-1:0][VPN_W-1:0] tags,
    input  logic [VPN_W-1:0]        vpn,
    output logic [N-1:0]            hit_vec,
    output logic                    hit,
    output logic [IDX_W-1:0]        hit_idx
);

    // one comparator per entry
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (tags[g] == vpn);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/xl_victim.sv
module xl_victim #(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     valid,
    input  logic [N-1:0]     used,
    output logic [IDX_W-1:0] victim,
    output logic             clear_used
);

    logic found;

    always_comb begin
        found      = 1'b0;
        victim     = '0;
        clear_used = 1'b0;
        // first choice: an empty slot, lowest index
        for (int i = 0; i < N; i++) begin
            if (!found && !valid[i]) begin
                victim = IDX_W'(i);
                found  = 1'b1;
            end
        end
        // second choice: a slot not touched since the last sweep
        for (int i = 0; i < N; i++) begin
            if (!found && !used[i]) begin
                victim = IDX_W'(i);
                found  = 1'b1;
            end
        end
        // all slots recently used: restart the sweep at slot 0
        if (!found) begin
            clear_used = 1'b1;
            victim     = '0;
        end
    end

endmodule

// File: rtl/vpn_xlate.sv
module vpn_xlate
    import vpn_xlate_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int OFF_W = 12,
    parameter int PPN_W = 20,
    parameter int N     = 4,
    parameter int MA_W  = 32,
    localparam int VA_W  = VPN_W + OFF_W,
    localparam int PA_W  = PPN_W + OFF_W,
    localparam int PTE_W = PPN_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             resp_valid,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             resp_dirty,
    output logic             fault,
    output logic             busy,
    input  logic             base_we,
    input  logic [MA_W-1:0]  base_wdata,
    input  logic             flush,
    output logic             mem_req,
    output logic [MA_W-1:0]  mem_addr,
    input  logic             mem_ack,
    input  logic [PTE_W-1:0] mem_rdata
);

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam int PTE_V = PPN_W + 1;
    localparam int PTE_D = PPN_W;

    typedef struct packed {
        xl_state_e               state;
        logic [MA_W-1:0]         base;
        logic [N-1:0]            v;
        logic [N-1:0]            d;
        logic [N-1:0]            r;
        logic [N-1:0][VPN_W-1:0] tag;
        logic [N-1:0][PPN_W-1:0] ppn;
        logic [VPN_W-1:0]        wvpn;
        logic [OFF_W-1:0]        woff;
        logic                    wwr;
        logic                    mem_req;
        logic [MA_W-1:0]         mem_addr;
        logic                    busy;
        logic                    rvalid;
        logic [PA_W-1:0]         rpaddr;
        logic                    rdirty;
        logic                    fault;
    } st_t;

    st_t q, n;

    logic [VPN_W-1:0] in_vpn;
    logic [OFF_W-1:0] in_off;
    logic [N-1:0]     hit_vec;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] vic_idx;
    logic             vic_clear;
    logic [MA_W-1:0]  base_now;

    assign in_vpn   = req_vaddr[VA_W-1:OFF_W];
    assign in_off   = req_vaddr[OFF_W-1:0];
    assign base_now = q.base;

    xl_match #(.N(N), .VPN_W(VPN_W)) u_match (
        .valid   (q.v),
        .tags    (q.tag),
        .vpn     (in_vpn),
        .hit_vec (hit_vec),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    xl_victim #(.N(N)) u_victim (
        .valid      (q.v),
        .used       (q.r),
        .victim     (vic_idx),
        .clear_used (vic_clear)
    );

    always_comb begin
        n        = q;
        n.rvalid = 1'b0;
        n.fault  = 1'b0;

        if (base_we) n.base = base_wdata;
        if (flush)   n.v    = '0;

        unique case (q.state)
            XL_IDLE: begin
                if (req_valid && !flush) begin
                    if (hit) begin
                        n.r[hit_idx] = 1'b1;
                        if (req_write) n.d[hit_idx] = 1'b1;
                        n.rvalid = 1'b1;
                        n.rpaddr = {q.ppn[hit_idx], in_off};
                        n.rdirty = q.d[hit_idx] | req_write;
                    end else begin
                        n.state    = XL_WALK;
                        n.busy     = 1'b1;
                        n.mem_req  = 1'b1;
                        n.mem_addr = q.base + MA_W'(in_vpn);
                        n.wvpn     = in_vpn;
                        n.woff     = in_off;
                        n.wwr      = req_write;
                    end
                end
            end
            XL_WALK: begin
                if (mem_ack) begin
                    n.state   = XL_IDLE;
                    n.busy    = 1'b0;
                    n.mem_req = 1'b0;
                    if (mem_rdata[PTE_V]) begin
                        if (vic_clear) n.r = '0;
                        n.v[vic_idx]   = 1'b1;
                        n.r[vic_idx]   = 1'b1;
                        n.tag[vic_idx] = q.wvpn;
                        n.ppn[vic_idx] = mem_rdata[PPN_W-1:0];
                        n.d[vic_idx]   = mem_rdata[PTE_D] | q.wwr;
                        n.rvalid = 1'b1;
                        n.rpaddr = {mem_rdata[PPN_W-1:0], q.woff};
                        n.rdirty = mem_rdata[PTE_D] | q.wwr;
                    end else begin
                        n.fault = 1'b1;
                    end
                end
            end
            default: n.state = XL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign resp_valid = q.rvalid;
    assign resp_paddr = q.rpaddr;
    assign resp_dirty = q.rdirty;
    assign fault      = q.fault;
    assign busy       = q.busy;
    assign mem_req    = q.mem_req;
    assign mem_addr   = q.mem_addr;

endmodule

// File: rtl/vpn_xlate_chk.sv
module vpn_xlate_chk #(
    parameter int VPN_W = 20,
    parameter int OFF_W = 12,
    parameter int PPN_W = 20,
    parameter int N     = 4,
    parameter int MA_W  = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic [VPN_W+OFF_W-1:0]   req_vaddr,
    input logic                     flush,
    input logic                     busy,
    input logic                     mem_req,
    input logic                     mem_ack,
    input logic [MA_W-1:0]          mem_addr,
    input logic [PPN_W+1:0]         mem_rdata,
    input logic                     resp_valid,
    input logic                     fault,
    input logic [MA_W-1:0]          base_now,
    input logic [N-1:0]             hit_vec
);

    assert_single_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    assert_walk_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> mem_addr == $past(base_now) + MA_W'($past(req_vaddr[VPN_W+OFF_W-1:OFF_W])));

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    assert_walk_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> !busy && !mem_req);

    assert_resp_fault_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_valid && fault));

    assert_fault_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(mem_req && mem_ack && !mem_rdata[PPN_W+1]));

    assert_busy_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid && !flush));

endmodule

bind vpn_xlate vpn_xlate_chk #(
    .VPN_W(VPN_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .N(N), .MA_W(MA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .flush      (flush),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .resp_valid (resp_valid),
    .fault      (fault),
    .base_now   (base_now),
    .hit_vec    (hit_vec)
);

// File: tb/vpn_xlate_test.sv
module vpn_xlate_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        resp_valid;
    logic [31:0] resp_paddr;
    logic        resp_dirty;
    logic        fault;
    logic        busy;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        flush = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [21:0] mem_rdata = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model of buffer contents
    logic        mv  [4];
    logic [19:0] mtag[4];
    logic [19:0] mppn[4];
    logic        md  [4];
    logic        mr  [4];
    logic [31:0] mbase = '0;

    always #10 clk = ~clk;

    vpn_xlate uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_vaddr(req_vaddr), .resp_valid(resp_valid), .resp_paddr(resp_paddr),
        .resp_dirty(resp_dirty), .fault(fault), .busy(busy), .base_we(base_we),
        .base_wdata(base_wdata), .flush(flush), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // table contents: bit21 valid, bit20 modified, bits19:0 page
    function automatic logic [21:0] pte_of(input logic [31:0] a);
        logic [31:0] p;
        p = a * 32'd13 + 32'd5;
        return {((a % 32'd7) != 32'd3), a[1], p[19:0]};
    endfunction

    task automatic set_base(input logic [31:0] b);
        base_we = 1'b1; base_wdata = b;
        @(negedge clk);
        base_we = 1'b0;
        mbase = b;
    endtask

    task automatic do_flush_with_req(input logic [19:0] vpn);
        flush = 1'b1; req_valid = 1'b1; req_vaddr = {vpn, 12'h010}; req_write = 1'b0;
        @(negedge clk);
        flush = 1'b0; req_valid = 1'b0;
        chk(resp_valid == 1'b0, "R10 request during flush gives no response", resp_valid, 0);
        chk(mem_req == 1'b0 && busy == 1'b0, "R10 request during flush starts no walk", mem_req, 0);
        for (int i = 0; i < 4; i++) mv[i] = 1'b0;
    endtask

    // one access; poke drives a stray request in the middle of a walk
    task automatic access(input logic [19:0] vpn, input logic [11:0] off, input bit wr, input bit poke);
        int hi;
        int dly;
        logic [31:0] pa;
        logic [21:0] pte;
        hi = -1;
        for (int i = 0; i < 4; i++) if (mv[i] && mtag[i] == vpn) hi = i;
        req_valid = 1'b1; req_vaddr = {vpn, off}; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        if (hi >= 0) begin
            chk(resp_valid == 1'b1, "R1 hit responds next edge", resp_valid, 1);
            chk(resp_paddr == {mppn[hi], off}, "R1 hit address", resp_paddr, {mppn[hi], off});
            chk(mem_req == 1'b0 && busy == 1'b0, "R1 hit without walk", {busy, mem_req}, 0);
            md[hi] = md[hi] | wr;
            mr[hi] = 1'b1;
            chk(resp_dirty == md[hi], "R5 modified flag on hit", resp_dirty, md[hi]);
        end else begin
            pa = mbase + {12'd0, vpn};
            pte = pte_of(pa);
            chk(busy == 1'b1 && mem_req == 1'b1, "R2 miss starts walk", {busy, mem_req}, 2'b11);
            chk(mem_addr == pa, "R2 walk address", mem_addr, pa);
            dly = poke ? 3 : int'((vpn + off) % 3);
            for (int k = 0; k < dly; k++) begin
                if (poke && k == 0) begin
                    req_valid = 1'b1; req_vaddr = {vpn ^ 20'h1, off}; req_write = 1'b0;
                end
                @(negedge clk);
                req_valid = 1'b0;
                if (poke && k == 0)
                    chk(resp_valid == 1'b0, "R10 request while busy ignored", resp_valid, 0);
                chk(mem_req == 1'b1 && mem_addr == pa, "R2 request held until ack", mem_addr, pa);
            end
            mem_ack = 1'b1; mem_rdata = pte;
            @(negedge clk);
            mem_ack = 1'b0;
            chk(busy == 1'b0 && mem_req == 1'b0, "R3 walk finishes", {busy, mem_req}, 0);
            if (pte[21]) begin
                chk(resp_valid == 1'b1 && fault == 1'b0, "R3 refill responds", {fault, resp_valid}, 1);
                chk(resp_paddr == {pte[19:0], off}, "R3 refill address", resp_paddr, {pte[19:0], off});
                chk(resp_dirty == (pte[20] | wr), "R5 modified flag on refill", resp_dirty, pte[20] | wr);
                // replacement per R6 / R7
                hi = -1;
                for (int i = 0; i < 4; i++) if (hi < 0 && !mv[i]) hi = i;
                for (int i = 0; i < 4; i++) if (hi < 0 && !mr[i]) hi = i;
                if (hi < 0) begin
                    for (int i = 0; i < 4; i++) mr[i] = 1'b0;
                    hi = 0;
                end
                mv[hi] = 1'b1; mr[hi] = 1'b1; mtag[hi] = vpn; mppn[hi] = pte[19:0];
                md[hi] = pte[20] | wr;
            end else begin
                chk(fault == 1'b1 && resp_valid == 1'b0, "R4 invalid entry faults", {fault, resp_valid}, 2'b10);
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            mv[i] = 0; mtag[i] = 0; mppn[i] = 0; md[i] = 0; mr[i] = 0;
        end
        repeat (3) @(negedge clk);
        chk(busy == 0 && mem_req == 0 && resp_valid == 0 && fault == 0, "R11 reset outputs",
            {busy, mem_req, resp_valid, fault}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: empty buffer, base 0 -> first walk reads vpn itself
        access(20'h00042, 12'h001, 1'b0, 1'b0);
        // R9: new base used by later walks
        set_base(32'h0010_0000);
        // R6 fill, R7 eviction sweep, R4 faulting pages revisited, R5 writes
        for (int rd = 0; rd < 6; rd++) begin
            for (int p = 0; p < 10; p++) begin
                access(20'(p), 12'(p * 37 + rd), ((p + rd) % 3) == 0, 1'b0);
            end
        end
        // R10: stray request during a walk
        access(20'h00123, 12'h0AB, 1'b1, 1'b1);
        // R8: flush, then previously held pages must walk
        do_flush_with_req(20'h00123);
        access(20'h00123, 12'h0AC, 1'b0, 1'b0);
        // R7: repeat pattern that touches one page often between misses
        for (int p = 0; p < 40; p++) begin
            access(20'((p % 2 == 0) ? 3 : (p % 9) + 20), 12'(p), p[2], 1'b0);
        end
        // R9: second base value, sweep again
        set_base(32'h0020_0405);
        for (int p = 0; p < 30; p++) begin
            access(20'(p % 7), 12'(p * 5), p[0], 1'b0);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule